// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Page Write Slave

This block is the write side of a small serial EEPROM sitting on a two-wire, I2C-style bus. It samples the bus clock and data lines with the system clock, recognises START and STOP conditions, and checks the first byte of each transfer against a fixed device code and chip-select value. A matched write control byte is acknowledged. The next byte loads the word-address pointer. The bytes that follow are collected in an eight-entry page buffer.

Nothing reaches the 128 x 8 memory array while the bus transfer is in progress. The buffered bytes are committed only when the master closes a clean transfer with STOP while the programming-enable input is high. The commit runs as a self-timed cycle of a parameterised number of system clocks. The block holds its busy output high for that cycle and answers no control byte until it ends. A combinational read port on the array lets neighbouring logic, such as a read-side controller, observe the stored contents.

Top module: `eeprom_page_writer`

## Requirements
- R1: A control byte of 8'hA0 (device code 1010 in bits 7:4, chip select 000 in bits 3:1, bit 0 = 0 for write), sent MSB first, is acknowledged. `sda_pull_o` goes high after the SCL falling edge that ends the eighth bit and drops after the SCL falling edge that ends the ninth bit.
- R2: A control byte whose device code or chip select differs, or whose bit 0 is 1, is not acknowledged. Everything up to the next START is then ignored, and no write cycle follows.
- R3: The byte after an acknowledged control byte is acknowledged and loaded into the 7-bit address pointer. Its bit 7 is ignored.
- R4: Each later data byte is acknowledged and buffered for the pointer's current location, and after the write cycle that location holds the byte.
- R5: After each data byte only pointer bits 2:0 increment. Bits 6:3 stay fixed, so writes wrap inside the aligned 8-byte page and never touch another page.
- R6: When more than eight data bytes arrive, a later byte replaces the earlier byte buffered at the same page offset.
- R7: A STOP at a byte boundary after at least one data byte starts the write cycle. `busy_o` is high for exactly WRITE_CYCLES system clocks, and the memory shows the new bytes only once `busy_o` has fallen.
- R8: While `busy_o` is high, no control byte is acknowledged, and the transfer it opens changes no memory location.
- R9: The write cycle starts only if `prog_en_i` is high when STOP is seen. If it is low, the bytes are discarded even though they were acknowledged. Dropping `prog_en_i` during the cycle does not abort it.
- R10: A STOP in the middle of a byte, a START before STOP, or a STOP with no data byte starts no write cycle and leaves the memory unchanged.
- R11: After reset `sda_pull_o` and `busy_o` are low and every memory location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low (open-drain acknowledge) |
| prog_en_i | input | 1 | Programming enable, sampled at STOP |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_raddr_i | input | 7 | Memory read port address |
| mem_rdata_o | output | 8 | Memory read port data (combinational) |

## Verification
The hardest situation to reach from the ports is a control byte that arrives while the self-timed cycle is still running. The bench reaches it by setting WRITE_CYCLES longer than a full bus byte. It starts a new transfer as soon as the STOP of a byte write has returned, which puts the control byte well inside the busy window. The page-wrap case is reached by starting at offset 5 of a page with address bit 7 set and sending ten bytes. The bench predicts the final contents of that page and of both neighbouring pages from its own model.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CTRL,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/eewr_bus_sync.sv
module eewr_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_ff[SYNC_STAGES-1];
         sda_q  <= sda_ff[SYNC_STAGES-1];
      end
   end

   assign scl_o      = scl_ff[SYNC_STAGES-1];
   assign sda_o      = sda_ff[SYNC_STAGES-1];
   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

   // START and STOP are mutually exclusive and never coincide with an SCL edge
   p_evt_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1);
endmodule

// File: rtl/eewr_page_buf.sv
module eewr_page_buf #(
   parameter int PAGE_W = 3,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr_i,
   input  logic                          wr_i,
   input  logic [PAGE_W-1:0]             wr_idx_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   output logic [(1<<PAGE_W)*DATA_W-1:0] data_o,
   output logic [(1<<PAGE_W)-1:0]        valid_o
);
   localparam int PAGE = 1 << PAGE_W;

   initial begin
      assert (PAGE_W >= 1 && PAGE_W <= 6) else $error("PAGE_W out of range");
   end

   for (genvar e = 0; e < PAGE; e++) begin : g_entry
      logic hit;
      assign hit = wr_i && (wr_idx_i == PAGE_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_o[e*DATA_W +: DATA_W] <= '0;
            valid_o[e]                 <= 1'b0;
         end else if (clr_i) begin
            valid_o[e] <= 1'b0;
         end else if (hit) begin
            data_o[e*DATA_W +: DATA_W] <= wr_data_i;
            valid_o[e]                 <= 1'b1;
         end
      end
   end

   // A buffered byte always leaves at least one valid entry (R4)
   p_wr_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i) |=> (valid_o != '0));
endmodule

// File: rtl/eewr_commit.sv
module eewr_commit #(
   parameter int ADDR_W       = 7,
   parameter int PAGE_W       = 3,
   parameter int DATA_W       = 8,
   parameter int WRITE_CYCLES = 1000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [ADDR_W-PAGE_W-1:0]      page_i,
   input  logic [(1<<PAGE_W)*DATA_W-1:0] buf_i,
   input  logic [(1<<PAGE_W)-1:0]        valid_i,
   input  logic [ADDR_W-1:0]             rd_addr_i,
   output logic [DATA_W-1:0]             rd_data_o,
   output logic                          busy_o
);
   localparam int PAGE  = 1 << PAGE_W;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HI_W  = ADDR_W - PAGE_W;
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   initial begin
      assert (WRITE_CYCLES >= 1) else $error("WRITE_CYCLES must be positive");
      assert (PAGE_W < ADDR_W) else $error("page must be smaller than the array");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt;
   logic [HI_W-1:0]   page_q;
   logic              done;

   assign done = busy_o && (cnt == CNT_W'(WRITE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
         page_q <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt    <= '0;
         page_q <= page_i;
      end else if (done) begin
         busy_o <= 1'b0;
      end else if (busy_o) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
      end else if (done) begin
         for (int i = 0; i < PAGE; i++) begin
            if (valid_i[i]) mem[{page_q, PAGE_W'(i)}] <= buf_i[i*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data_o = mem[rd_addr_i];

   // The cycle counter never passes the programmed length (R7)
   p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt < CNT_W'(WRITE_CYCLES)));
   // A new cycle is never requested while one is running (R8)
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import eewr_pkg::*;
#(
   parameter int         ADDR_W       = 7,
   parameter int         PAGE_W       = 3,
   parameter int         WRITE_CYCLES = 1000,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [3:0] DEV_CODE     = 4'b1010,
   parameter logic [2:0] CHIP_SEL     = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              prog_en_i,
   output logic              busy_o,
   input  logic [ADDR_W-1:0] mem_raddr_i,
   output logic [BYTE_W-1:0] mem_rdata_o
);
   localparam int PAGE = 1 << PAGE_W;
   localparam int HI_W = ADDR_W - PAGE_W;

   initial begin
      assert (ADDR_W <= BYTE_W) else $error("address must fit in one byte");
      assert (PAGE_W < ADDR_W) else $error("page must be smaller than the array");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

   eewr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_evt), .stop_o(stop_evt)
   );

   phase_e            phase;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              in_ack, pull, got_data;
   logic [ADDR_W-1:0] ptr;
   logic              byte_end, ctrl_match, commit_go, buf_clr, buf_wr;
   logic [PAGE*BYTE_W-1:0] buf_data;
   logic [PAGE-1:0]   buf_valid;

   assign byte_end   = scl_fall && !in_ack && (bitcnt == 4'd8);
   assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == CHIP_SEL) && !shreg[0];
   assign buf_clr    = byte_end && (phase == PH_ADDR);
   assign buf_wr     = byte_end && (phase == PH_DATA);
   // STOP's own SCL rise adds one sampled bit, so a byte boundary shows as a count of 0 or 1
   assign commit_go  = stop_evt && (phase == PH_DATA) && !in_ack && (bitcnt <= 4'd1)
                       && got_data && prog_en_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         in_ack   <= 1'b0;
         pull     <= 1'b0;
         got_data <= 1'b0;
         ptr      <= '0;
      end else if (start_evt) begin
         phase    <= PH_CTRL;
         bitcnt   <= '0;
         in_ack   <= 1'b0;
         pull     <= 1'b0;
         got_data <= 1'b0;
      end else if (stop_evt) begin
         phase  <= PH_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         pull   <= 1'b0;
      end else begin
         if (scl_rise && !in_ack && (bitcnt < 4'd8) &&
             (phase != PH_IDLE) && (phase != PH_SKIP)) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
         end
         if (scl_fall && in_ack) begin
            pull   <= 1'b0;
            in_ack <= 1'b0;
            bitcnt <= '0;
         end else if (byte_end) begin
            case (phase)
               PH_CTRL: begin
                  if (ctrl_match && !busy_o) begin
                     pull   <= 1'b1;
                     in_ack <= 1'b1;
                     phase  <= PH_ADDR;
                  end else begin
                     phase <= PH_SKIP;
                  end
               end
               PH_ADDR: begin
                  ptr    <= shreg[ADDR_W-1:0];
                  pull   <= 1'b1;
                  in_ack <= 1'b1;
                  phase  <= PH_DATA;
               end
               PH_DATA: begin
                  ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                  got_data        <= 1'b1;
                  pull            <= 1'b1;
                  in_ack          <= 1'b1;
               end
               default: phase <= PH_SKIP;
            endcase
         end
      end
   end

   eewr_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
      .wr_idx_i(ptr[PAGE_W-1:0]), .wr_data_i(shreg),
      .data_o(buf_data), .valid_o(buf_valid)
   );

   eewr_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W),
                 .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .start_i(commit_go), .page_i(ptr[ADDR_W-1:PAGE_W]),
      .buf_i(buf_data), .valid_i(buf_valid), .rd_addr_i(mem_raddr_i),
      .rd_data_o(mem_rdata_o), .busy_o(busy_o)
   );

   assign sda_pull_o = pull;

   // The acknowledge pull only starts while the bus clock is low (R1)
   p_ack_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> !scl_s);
   // The bus stays silent during the self-timed cycle (R8)
   p_silent_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !pull);
   // The page part of the pointer is frozen while data bytes stream in (R5)
   p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |=> $stable(ptr[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
   localparam int CLK_P = 10;
   localparam int Q     = 6;
   localparam int WCYC  = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic prog_en = 1'b1;
   logic [6:0] raddr = '0;
   logic sda_pull, busy, sda_bus;
   logic [7:0] rdata;
   int checks = 0;
   int errors = 0;
   int busy_run = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;
   assign sda_bus = sda_m & ~sda_pull;

   eeprom_page_writer #(.WRITE_CYCLES(WCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .prog_en_i(prog_en), .busy_o(busy),
      .mem_raddr_i(raddr), .mem_rdata_o(rdata)
   );

   always @(negedge clk) if (busy) busy_run <= busy_run + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(Q);
         scl_m = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q/2);
      ack = ~sda_bus;
      tick(Q - Q/2);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic read_mem(input logic [6:0] a, output logic [7:0] d);
      raddr = a; tick(1);
      d = rdata;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin tick(1); n++; end
      tick(2);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R11 pull after reset", sda_pull, 0);
      chk("R11 busy after reset", busy, 0);
      read_mem(7'h00, d); chk("R11 mem[00] erased", d, 8'hFF);
      read_mem(7'h7F, d); chk("R11 mem[7F] erased", d, 8'hFF);
   endtask

   task automatic t_byte_write();
      logic ack; logic [7:0] d;
      bus_start();
      send_byte(8'hA0, ack); chk("R1 control byte acked", ack, 1);
      chk("R1 pull released after ninth clock", sda_pull, 0);
      send_byte(8'h05, ack); chk("R3 address acked", ack, 1);
      send_byte(8'h3C, ack); chk("R4 data acked", ack, 1);
      busy_run = 0;
      bus_stop();
      chk("R7 busy after STOP", busy, 1);
      read_mem(7'h05, d); chk("R7 old value while busy", d, 8'hFF);
      wait_idle();
      chk("R7 busy length", busy_run, WCYC);
      read_mem(7'h05, d); chk("R4 byte committed", d, 8'h3C);
   endtask

   task automatic t_page_wrap();
      logic ack; logic [7:0] d;
      logic [7:0] exp [128];
      for (int a = 0; a < 128; a++) exp[a] = 8'hFF;
      exp[5] = 8'h3C;
      bus_start();
      send_byte(8'hA0, ack);
      send_byte(8'h8D, ack); chk("R3 address with bit 7 set acked", ack, 1);
      for (int i = 0; i < 10; i++) begin
         send_byte(8'h10 + 8'(i), ack);
         chk("R6 page byte acked", ack, 1);
         exp[8 + ((5 + i) % 8)] = 8'h10 + 8'(i);
      end
      bus_stop();
      wait_idle();
      for (int a = 0; a < 24; a++) begin
         read_mem(7'(a), d);
         chk((a >= 8 && a < 16) ? "R6 page content after wrap" : "R5 neighbour page untouched",
             d, exp[a]);
      end
      read_mem(7'h0D, d); chk("R6 offset 5 overwritten by ninth byte", d, 8'h18);
      read_mem(7'h0F, d); chk("R5 offset 7 keeps third byte", d, 8'h12);
      read_mem(7'h4D, d); chk("R3 bit 7 ignored, mem[4D] untouched", d, 8'hFF);
   endtask

   task automatic t_busy_nack();
      logic ack; logic [7:0] d;
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h20, ack); send_byte(8'h55, ack);
      bus_stop();
      bus_start();
      chk("R8 busy while retrying", busy, 1);
      send_byte(8'hA0, ack); chk("R8 control byte not acked while busy", ack, 0);
      send_byte(8'h21, ack); send_byte(8'hEE, ack);
      bus_stop();
      wait_idle();
      read_mem(7'h20, d); chk("R8 first write kept", d, 8'h55);
      read_mem(7'h21, d); chk("R8 rejected write absent", d, 8'hFF);
   endtask

   task automatic t_bad_ctrl();
      logic ack; logic [7:0] d;
      logic [7:0] bad [3] = '{8'hA2, 8'hB0, 8'hA1};
      for (int k = 0; k < 3; k++) begin
         bus_start();
         send_byte(bad[k], ack); chk("R2 foreign control byte not acked", ack, 0);
         send_byte(8'h60, ack); chk("R2 later byte ignored", ack, 0);
         send_byte(8'h99, ack);
         bus_stop(); tick(10);
         chk("R2 no write cycle", busy, 0);
      end
      read_mem(7'h60, d); chk("R2 memory untouched", d, 8'hFF);
   endtask

   task automatic t_prog_en();
      logic ack; logic [7:0] d;
      prog_en = 1'b0;
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h30, ack);
      send_byte(8'h77, ack); chk("R9 data acked with enable low", ack, 1);
      bus_stop(); tick(10);
      chk("R9 no cycle with enable low", busy, 0);
      read_mem(7'h30, d); chk("R9 memory untouched with enable low", d, 8'hFF);
      prog_en = 1'b1;
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h31, ack); send_byte(8'h88, ack);
      bus_stop();
      chk("R9 cycle started", busy, 1);
      tick(20);
      prog_en = 1'b0;
      wait_idle();
      prog_en = 1'b1;
      read_mem(7'h31, d); chk("R9 enable drop does not abort", d, 8'h88);
   endtask

   task automatic t_abort();
      logic ack; logic [7:0] d;
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h40, ack); send_byte(8'h11, ack);
      send_bits(8'hF0, 3);
      bus_stop(); tick(10);
      chk("R10 mid-byte STOP starts nothing", busy, 0);
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h41, ack); send_byte(8'h22, ack);
      send_bits(8'h0F, 4);
      bus_start();
      bus_stop(); tick(10);
      chk("R10 START before STOP starts nothing", busy, 0);
      bus_start();
      send_byte(8'hA0, ack); send_byte(8'h42, ack);
      bus_stop(); tick(10);
      chk("R10 STOP without data starts nothing", busy, 0);
      read_mem(7'h40, d); chk("R10 mem[40] untouched", d, 8'hFF);
      read_mem(7'h41, d); chk("R10 mem[41] untouched", d, 8'hFF);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_byte_write();
      t_page_wrap();
      t_busy_nack();
      t_bad_ctrl();
      t_prog_en();
      t_abort();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog (all R): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule